// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block generates the reset that holds a processor in a known state. It watches two trigger sources. The first is a supply-low flag that an external threshold comparator raises asynchronously. The second is an active-low manual reset input, which may come from a push button or from another logic output. The reset is driven on two outputs of opposite polarity: one active low and one active high.

Reset is asserted at once while either source is active. Once the last source has released, reset stays asserted for a hold interval. The interval is counted in pulses of a slow timebase enable, and its length is set by a parameter.

A new trigger during the hold sends the count back to zero, so reset then lasts a further full interval after that trigger ends. The same restart debounces a mechanical switch: each bounce that goes low starts the interval again, and reset is released only after the contacts have stayed quiet for a whole interval. The block also starts with reset asserted after its asynchronous system reset. A complete hold interval therefore follows power-up, which gives the power-on reset.

Top module: `supv_reset_gen`

## Requirements
- R1: While the asynchronous reset `arst_n` is low, and directly after it is released, `rst_n_o` is 0 and `rst_o` is 1. With no trigger active, reset is released on the clock edge that consumes the HOLD_TICKS-th `tick_i` pulse after `arst_n` goes high.
- R2: A 1 on `supply_low_i` asserts reset on the third rising clock edge after the input changes: two synchroniser edges and one state edge. Reset stays asserted for as long as the flag is 1, however many `tick_i` pulses arrive.
- R3: A 0 on `man_rst_n_i` asserts reset with the same three-edge latency. Reset stays asserted for as long as the input is 0, however many `tick_i` pulses arrive.
- R4: Once the synchronised triggers are both inactive, reset stays asserted through HOLD_TICKS-1 `tick_i` pulses. It is released on the edge that consumes the HOLD_TICKS-th pulse.
- R5: A trigger seen during the hold clears the count. A full HOLD_TICKS pulses are then needed after that trigger releases.
- R6: A low pulse on `man_rst_n_i` of one clock cycle or longer during the hold restarts the interval. After a burst of such bounces, reset is released exactly HOLD_TICKS pulses after the last one.
- R7: `rst_o` is the logical inverse of `rst_n_o` on every cycle.
- R8: While no trigger is active, a clock edge with `tick_i` at 0 changes neither output. While reset is released, `tick_i` pulses with no trigger keep reset released.
- R9: When both sources overlap, reset stays asserted until the later of the two releases. The full hold interval then follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous system reset, active low |
| tick_i | input | 1 | Timebase enable, one clock wide per tick |
| supply_low_i | input | 1 | Asynchronous supply-low flag, active high |
| man_rst_n_i | input | 1 | Asynchronous manual reset, active low |
| rst_n_o | output | 1 | Reset output, active low |
| rst_o | output | 1 | Reset output, active high |

## Verification
The bench builds the block with HOLD_TICKS set to 5 and the default two synchroniser stages, and drives the timebase enable directly, one pulse at a time. The short interval lets every scenario reach the last tick of the hold. Retrigger and bounce can therefore be placed on the final count before release, and the off-by-one boundary between HOLD_TICKS-1 and HOLD_TICKS pulses can be checked in every scenario.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Width needed to hold counts 0 .. limit-1 (at least one bit).
  function automatic int unsigned hold_cnt_width(int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

  // True when count c is the final tick of an interval of length limit.
  function automatic bit hold_at_end(int unsigned c, int unsigned limit);
    return (c + 1) >= limit;
  endfunction

  // Next value of the hold count given trigger, enable and end flag.
  function automatic int unsigned hold_cnt_step(int unsigned c, bit trig,
                                                bit adv, bit at_end);
    if (trig)        return 0;
    else if (!adv)   return c;
    else if (at_end) return 0;
    else             return c + 1;
  endfunction

  // Per-bit reset image of the synchroniser: supply flag idle 0, manual idle 1.
  localparam logic [1:0] SYNC_IDLE = 2'b10;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned      WIDTH    = 2,
  parameter int unsigned      STAGES   = 2,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[0] <= IDLE_VAL;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[s] <= IDLE_VAL;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/supv_hold.sv
module supv_hold
  import supv_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 200,
  localparam int unsigned CW = hold_cnt_width(HOLD_TICKS)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          trig_i,
  input  logic          tick_i,
  output logic          active_nxt_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_end;
  logic          adv;

  // Counting only happens while holding and no source is active.
  assign adv    = active_q && !trig_i && tick_i;
  assign at_end = hold_at_end(int'(cnt_q), HOLD_TICKS);
  assign done_o = adv && at_end;

  always_comb begin
    cnt_d = CW'(hold_cnt_step(int'(cnt_q), trig_i, adv, at_end));
    if (trig_i)      active_nxt_o = 1'b1;
    else if (done_o) active_nxt_o = 1'b0;
    else             active_nxt_o = active_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      active_q <= active_nxt_o;
      cnt_q    <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/supv_drive.sv
module supv_drive (
  input  logic clk,
  input  logic arst_n,
  input  logic active_nxt_i,
  output logic rst_n_o,
  output logic rst_o
);

  // Two separate flops, one per polarity, both loaded from the same decision.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_n_o <= 1'b0;
    else         rst_n_o <= ~active_nxt_i;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_o <= 1'b1;
    else         rst_o <= active_nxt_i;
  end

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned HOLD_TICKS  = 200,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = hold_cnt_width(HOLD_TICKS)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_i,
  input  logic supply_low_i,
  input  logic man_rst_n_i,
  output logic rst_n_o,
  output logic rst_o
);

  logic [1:0]       raw_w;
  logic [1:0]       sync_w;
  logic             supply_low_s;
  logic             man_low_s;
  logic             trig_w;
  logic             active_nxt_w;
  logic             hold_done_w;
  logic [CNT_W-1:0] hold_cnt_w;

  assign raw_w = {man_rst_n_i, supply_low_i};

  supv_sync #(
    .WIDTH    (2),
    .STAGES   (SYNC_STAGES),
    .IDLE_VAL (SYNC_IDLE)
  ) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d_i    (raw_w),
    .q_o    (sync_w)
  );

  assign supply_low_s = sync_w[0];
  assign man_low_s    = ~sync_w[1];
  assign trig_w       = supply_low_s | man_low_s;

  supv_hold #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_hold (
    .clk          (clk),
    .arst_n       (arst_n),
    .trig_i       (trig_w),
    .tick_i       (tick_i),
    .active_nxt_o (active_nxt_w),
    .done_o       (hold_done_w),
    .cnt_o        (hold_cnt_w)
  );

  supv_drive u_drive (
    .clk          (clk),
    .arst_n       (arst_n),
    .active_nxt_i (active_nxt_w),
    .rst_n_o      (rst_n_o),
    .rst_o        (rst_o)
  );

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int unsigned HOLD_TICKS = 200,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          arst_n,
  input logic          tick_i,
  input logic          trig,
  input logic          done,
  input logic [CW-1:0] cnt,
  input logic          rst_n_o,
  input logic          rst_o
);

  // R7: the two output flops always disagree
  p_inverse_r7: assert property (@(posedge clk) disable iff (!arst_n)
    rst_o == ~rst_n_o);

  // R2 / R3: an active synchronised source asserts reset on the next edge
  p_trig_asserts_r2: assert property (@(posedge clk) disable iff (!arst_n)
    trig |=> !rst_n_o);

  // R5: an active source leaves the count at zero
  p_restart_r5: assert property (@(posedge clk) disable iff (!arst_n)
    trig |=> (cnt == '0));

  // R4: release only after the final tick of the interval
  p_release_r4: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> $past(done));

  // R4: the count never runs past the interval length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!arst_n)
    int'(cnt) < HOLD_TICKS);

  // R8: without a tick and without a source the outputs stay put
  p_quiet_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (!tick_i && !trig) |=> $stable(rst_n_o));

endmodule

bind supv_reset_gen supv_reset_gen_chk #(
  .HOLD_TICKS (HOLD_TICKS),
  .CW         (CNT_W)
) u_chk (
  .clk     (clk),
  .arst_n  (arst_n),
  .tick_i  (tick_i),
  .trig    (trig_w),
  .done    (hold_done_w),
  .cnt     (hold_cnt_w),
  .rst_n_o (rst_n_o),
  .rst_o   (rst_o)
);

// File: tb/supv_reset_gen_bench.sv
`timescale 1ns/1ps
module supv_reset_gen_bench;

  localparam int unsigned HT = 5;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic tick_i = 1'b0;
  logic supply_low_i = 1'b0;
  logic man_rst_n_i = 1'b1;
  logic rst_n_o, rst_o;

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  supv_reset_gen #(.HOLD_TICKS(HT), .SYNC_STAGES(2)) u_supv_reset_gen (
    .clk          (clk),
    .arst_n       (arst_n),
    .tick_i       (tick_i),
    .supply_low_i (supply_low_i),
    .man_rst_n_i  (man_rst_n_i),
    .rst_n_o      (rst_n_o),
    .rst_o        (rst_o)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Reset asserted (1) or released (0) on both outputs, R7 checked alongside.
  task automatic chk_rst(string req, string what, logic exp_asserted);
    chk(req, what, rst_n_o, ~exp_asserted);
    chk("R7", what, rst_o, ~rst_n_o);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  // After all sources are released and flushed: HT-1 ticks hold, one more releases.
  task automatic expect_full_hold(string req);
    cyc(3);
    chk_rst(req, "held after flush", 1'b1);
    ticks(HT - 1);
    chk_rst(req, "held after HT-1 ticks", 1'b1);
    ticks(1);
    chk_rst(req, "released on tick HT", 1'b0);
  endtask

  task automatic t_power_on;
    cyc(2);
    chk_rst("R1", "asserted in reset", 1'b1);
    arst_n = 1'b1;
    cyc(1);
    chk_rst("R1", "asserted after release", 1'b1);
    ticks(HT - 1);
    chk_rst("R1", "held after HT-1 ticks", 1'b1);
    ticks(1);
    chk_rst("R1", "released after HT ticks", 1'b0);
  endtask

  task automatic t_idle_ticks;
    ticks(3 * HT);
    chk_rst("R8", "ticks with no trigger", 1'b0);
    cyc(4);
    chk_rst("R8", "idle edges", 1'b0);
  endtask

  task automatic t_supply;
    supply_low_i = 1'b1;
    cyc(2);
    chk_rst("R2", "not yet after 2 edges", 1'b0);
    cyc(1);
    chk_rst("R2", "asserted on edge 3", 1'b1);
    ticks(3 * HT);
    chk_rst("R2", "held while flag set", 1'b1);
    supply_low_i = 1'b0;
    expect_full_hold("R4");
  endtask

  task automatic t_manual;
    man_rst_n_i = 1'b0;
    cyc(2);
    chk_rst("R3", "not yet after 2 edges", 1'b0);
    cyc(1);
    chk_rst("R3", "asserted on edge 3", 1'b1);
    ticks(2 * HT);
    chk_rst("R3", "held while input low", 1'b1);
    man_rst_n_i = 1'b1;
    expect_full_hold("R3");
  endtask

  task automatic t_retrigger;
    supply_low_i = 1'b1;
    cyc(4);
    supply_low_i = 1'b0;
    cyc(3);
    ticks(HT - 1);
    chk_rst("R5", "held before dip", 1'b1);
    supply_low_i = 1'b1;
    cyc(2);
    supply_low_i = 1'b0;
    cyc(3);
    ticks(HT - 1);
    chk_rst("R5", "count restarted", 1'b1);
    ticks(1);
    chk_rst("R5", "released after full restart", 1'b0);
  endtask

  task automatic t_bounce;
    man_rst_n_i = 1'b0;
    cyc(4);
    for (int b = 0; b < 3; b++) begin
      man_rst_n_i = 1'b1;
      cyc(3);
      ticks(HT - 1 - b);
      man_rst_n_i = 1'b0;
      cyc(1);
    end
    man_rst_n_i = 1'b1;
    cyc(3);
    ticks(HT - 1);
    chk_rst("R6", "held after bounce burst", 1'b1);
    ticks(1);
    chk_rst("R6", "released after quiet interval", 1'b0);
  endtask

  task automatic t_overlap;
    supply_low_i = 1'b1;
    cyc(2);
    man_rst_n_i = 1'b0;
    cyc(4);
    supply_low_i = 1'b0;
    cyc(3);
    ticks(2 * HT);
    chk_rst("R9", "held while manual still low", 1'b1);
    man_rst_n_i = 1'b1;
    expect_full_hold("R9");
  endtask

  initial begin
    @(negedge clk);
    t_power_on();
    t_idle_ticks();
    t_supply();
    t_manual();
    t_retrigger();
    t_bounce();
    t_overlap();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

endmodule